// File: doc/BRIEF.md
# Vector Shift-Right with Rounding and Accumulate

This unit takes a 128-bit source vector and shifts every element right by one immediate amount. Elements may be 8, 16, 32 or 64 bits wide. Each element is treated as signed (arithmetic shift) or unsigned (logical shift). Round-to-nearest can be enabled. The shifted element can also be added back onto the matching element of the old destination vector, and that sum wraps within the element.

A register-width control picks either the full 128-bit vector or only its low 64 bits. A scalar control limits the operation to element 0. Every bit that the chosen form does not produce is cleared in the result. One set of operands is accepted per cycle, and the result is registered one cycle later. The block is meant to sit behind an instruction decoder that supplies the control fields directly.

Top module: `vshr_acc_unit`

## Requirements
- R1: Reset clears `result` and `out_valid`. `out_valid` is high exactly one cycle after `in_valid` was high. `result` changes only in that cycle and holds its value through idle cycles.
- R2: `elem_size` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies bits [i*W +: W]. With `signed_mode` low, each element is shifted right logically by `shift_amt`, which must lie in 1..W.
- R3: With `signed_mode` high, each element is shifted right arithmetically, so the vacated high bits copy the element's sign bit.
- R4: With `round_en` high, the result equals (element + 2^(shift-1)) >> shift computed without overflow. This holds for 64-bit elements too.
- R5: With `accum_en` high, the shifted element is added to the matching element of `dst_vec`, and the sum wraps modulo 2^W. No carry passes into a neighbouring element.
- R6: With `wide_reg` low, only the elements in source bits [63:0] are processed, and `result[127:64]` is zero.
- R7: With `scalar_mode` high, only element 0 is processed, and every result bit above it is zero, whatever `wide_reg` says.
- R8: A shift equal to W yields 0 for unsigned elements and the sign fill (all zeros or all ones) for signed elements. When rounding is on, the rounding bit is still added, so for example an unsigned 8-bit 0xFF shifted by 8 with rounding gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Old destination vector, used as the accumulate addend |
| elem_size | input | 2 | Element width code: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64 |
| shift_amt | input | 7 | Right-shift amount, 1..element width |
| signed_mode | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| round_en | input | 1 | 1 = round to nearest |
| accum_en | input | 1 | 1 = add the result to the `dst_vec` element |
| scalar_mode | input | 1 | 1 = element 0 only |
| wide_reg | input | 1 | 1 = 128-bit register form, 0 = 64-bit form |
| out_valid | output | 1 | `result` was updated at the last edge |
| result | output | 128 | Registered result vector |

## Verification
Every result is due at the first rising edge after the cycle in which `in_valid` is high. It can be seen from the falling edge that follows that edge. The driver changes operands on falling edges and queues an independently computed expected vector for each one. The monitor pops that entry at the next falling edge on which `out_valid` is high. On falling edges with `out_valid` low, the monitor checks that `result` still equals the last expected vector. This confirms that idle cycles leave the output untouched.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int SHW    = 7;
  localparam int NSIZES = 4;

  // width in bits of an element for a size code
  function automatic int elem_bits(input logic [1:0] sz);
    return 8 << sz;
  endfunction

  // bits of the result that the selected form is allowed to produce
  function automatic logic [VEC_W-1:0] keep_mask(input logic [1:0] sz,
                                                 input logic wide,
                                                 input logic scalar);
    logic [VEC_W-1:0] m;
    if (scalar)
      m = {VEC_W{1'b1}} >> (VEC_W - elem_bits(sz));
    else if (!wide)
      m = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    else
      m = {VEC_W{1'b1}};
    return m;
  endfunction
endpackage

// File: rtl/vshr_lane.sv
module vshr_lane #(
  parameter int EW  = 8,
  parameter int SHW = 7
) (
  input  logic [EW-1:0]  src_el,
  input  logic [EW-1:0]  dst_el,
  input  logic [SHW-1:0] shift_amt,
  input  logic           signed_mode,
  input  logic           round_en,
  input  logic           accum_en,
  output logic [EW-1:0]  res_el
);
  // one guard bit above the element keeps shift-by-width well defined
  logic signed [EW:0] ext;
  logic        [EW:0] shifted;
  logic               round_bit;
  logic        [EW-1:0] trunc_rnd;
  logic               unused_hi;

  // last bit dropped by the shift; adding it equals pre-adding half an LSB
  function automatic logic cut_bit(input logic [EW:0] v, input logic [SHW-1:0] s);
    logic [EW:0] sel;
    sel = {{EW{1'b0}}, 1'b1} << (s - 1'b1);
    return |(v & sel);
  endfunction

  assign ext       = {signed_mode & src_el[EW-1], src_el};
  assign shifted   = ext >>> shift_amt;
  assign round_bit = round_en & cut_bit(ext, shift_amt);
  assign trunc_rnd = shifted[EW-1:0] + {{(EW-1){1'b0}}, round_bit};
  assign res_el    = trunc_rnd + (accum_en ? dst_el : '0);
  assign unused_hi = shifted[EW];
endmodule

// File: rtl/vshr_lane_group.sv
module vshr_lane_group #(
  parameter int VW  = 128,
  parameter int EW  = 8,
  parameter int SHW = 7
) (
  input  logic [VW-1:0]  src_vec,
  input  logic [VW-1:0]  dst_vec,
  input  logic [SHW-1:0] shift_amt,
  input  logic           signed_mode,
  input  logic           round_en,
  input  logic           accum_en,
  output logic [VW-1:0]  res_vec
);
  localparam int NLANES = VW / EW;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    vshr_lane #(.EW(EW), .SHW(SHW)) u_lane (
      .src_el     (src_vec[i*EW +: EW]),
      .dst_el     (dst_vec[i*EW +: EW]),
      .shift_amt  (shift_amt),
      .signed_mode(signed_mode),
      .round_en   (round_en),
      .accum_en   (accum_en),
      .res_el     (res_vec[i*EW +: EW])
    );
  end
endmodule

// File: rtl/vshr_acc_unit.sv
module vshr_acc_unit
  import vshr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [127:0]     src_vec,
  input  logic [127:0]     dst_vec,
  input  logic [1:0]       elem_size,
  input  logic [6:0]       shift_amt,
  input  logic             signed_mode,
  input  logic             round_en,
  input  logic             accum_en,
  input  logic             scalar_mode,
  input  logic             wide_reg,
  output logic             out_valid,
  output logic [127:0]     result
);
  logic [VEC_W-1:0] grp_res [NSIZES];
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] keep;
  logic [VEC_W-1:0] next_res;

  // one lane group per element width; the size code picks one
  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    vshr_lane_group #(.VW(VEC_W), .EW(8 << g), .SHW(SHW)) u_grp (
      .src_vec    (src_vec),
      .dst_vec    (dst_vec),
      .shift_amt  (shift_amt),
      .signed_mode(signed_mode),
      .round_en   (round_en),
      .accum_en   (accum_en),
      .res_vec    (grp_res[g])
    );
  end

  assign sel_res  = grp_res[elem_size];
  assign keep     = keep_mask(elem_size, wide_reg, scalar_mode);
  assign next_res = sel_res & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/vshr_acc_unit_chk.sv
module vshr_acc_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   elem_size,
  input logic [6:0]   shift_amt,
  input logic         signed_mode,
  input logic         round_en,
  input logic         accum_en,
  input logic         scalar_mode,
  input logic         wide_reg,
  input logic         out_valid,
  input logic [127:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                              // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));                       // R1
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!wide_reg || scalar_mode)) |=> (result[127:64] == '0)); // R6
  AST_SCALAR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode && elem_size == 2'd0) |=> (result[127:8] == '0)); // R7
  AST_FULL_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signed_mode && !round_en && !accum_en &&
     shift_amt == (7'd8 << elem_size)) |=> (result == '0));               // R8
endmodule

bind vshr_acc_unit vshr_acc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .elem_size  (elem_size),
  .shift_amt  (shift_amt),
  .signed_mode(signed_mode),
  .round_en   (round_en),
  .accum_en   (accum_en),
  .scalar_mode(scalar_mode),
  .wide_reg   (wide_reg),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/vshr_acc_unit_test.sv
`timescale 1ns/1ps
module vshr_acc_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec, dst_vec;
  logic [1:0]   elem_size;
  logic [6:0]   shift_amt;
  logic         signed_mode, round_en, accum_en, scalar_mode, wide_reg;
  logic         out_valid;
  logic [127:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 0;
  bit have_last = 0;
  logic [127:0] last_exp = '0;

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  vshr_acc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .dst_vec(dst_vec), .elem_size(elem_size),
    .shift_amt(shift_amt), .signed_mode(signed_mode), .round_en(round_en),
    .accum_en(accum_en), .scalar_mode(scalar_mode), .wide_reg(wide_reg),
    .out_valid(out_valid), .result(result)
  );

  // reference: add rounding constant in a 66-bit field, then shift
  function automatic logic [127:0] model(
      input logic [127:0] s, input logic [127:0] d, input logic [1:0] sz,
      input int sh, input bit sg, input bit rn, input bit ac,
      input bit sc, input bit wd);
    logic [127:0]       r;
    logic signed [65:0] e;
    logic [63:0]        a, b, o;
    int ew, n;
    ew = 8 << sz;
    n  = sc ? 1 : ((wd ? 16 : 8) >> sz);
    r  = '0;
    for (int i = 0; i < n; i++) begin
      a = '0; b = '0;
      for (int k = 0; k < ew; k++) begin
        a[k] = s[i*ew + k];
        b[k] = d[i*ew + k];
      end
      e = {2'b00, a};
      if (sg && a[ew-1])
        for (int k = ew; k < 66; k++) e[k] = 1'b1;
      if (rn) e = e + (66'sd1 <<< (sh - 1));
      e = e >>> sh;
      o = e[63:0] + (ac ? b : 64'd0);
      for (int k = 0; k < ew; k++) r[i*ew + k] = o[k];
    end
    return r;
  endfunction

  task automatic drive(input logic [127:0] s, input logic [127:0] d,
                       input logic [1:0] sz, input int sh, input bit sg,
                       input bit rn, input bit ac, input bit sc, input bit wd,
                       input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; src_vec = s; dst_vec = d; elem_size = sz;
    shift_amt = 7'(sh); signed_mode = sg; round_en = rn; accum_en = ac;
    scalar_mode = sc; wide_reg = wd;
    it.exp = model(s, d, sz, sh, sg, rn, ac, sc, wd);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_vec  = {4{32'hDEADBEEF}};
    end
  endtask

  // monitor: compare on out_valid, check holding otherwise
  always @(negedge clk) begin
    if (started) begin
      if (out_valid) begin
        item_t it;
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1: out_valid with no pending item, got %h expected none", result);
        end else begin
          it = sb_q.pop_front();
          if (result !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
          end
          last_exp  = it.exp;
          have_last = 1;
        end
      end else if (have_last) begin
        n_checks++;  // R1 hold
        if (result !== last_exp) begin
          n_fail++;
          $display("FAIL R1 hold: got %h expected %h", result, last_exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; dst_vec = '0;
    elem_size = '0; shift_amt = 7'd1; signed_mode = 0; round_en = 0;
    accum_en = 0; scalar_mode = 0; wide_reg = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;  // R1 reset state
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got %b/%h expected 0/0", out_valid, result);
    end
    rst_n = 1'b1;
    started = 1;

    // R2 logical shift, bytes
    drive({16{8'h80}}, '0, 2'd0, 1, 0, 0, 0, 0, 1, "R2");
    drive(128'h0123456789ABCDEF_FEDCBA9876543210, '0, 2'd1, 3, 0, 0, 0, 0, 1, "R2");
    idle(2);
    // R3 arithmetic shift
    drive({8{16'hF00F}}, '0, 2'd1, 4, 1, 0, 0, 0, 1, "R3");
    drive({2{64'h8000_0000_0000_0001}}, '0, 2'd3, 63, 1, 0, 0, 0, 1, "R3");
    // R4 rounding incl 64-bit without overflow
    drive({8{8'h03, 8'hFF}}, '0, 2'd0, 1, 0, 1, 0, 0, 1, "R4");
    drive({2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 2'd3, 1, 0, 1, 0, 0, 1, "R4");
    drive({4{32'hFFFF_FFFB}}, '0, 2'd2, 1, 1, 1, 0, 0, 1, "R4");
    idle(1);
    // R5 accumulate wraps per element
    drive({16{8'h02}}, {16{8'hFF}}, 2'd0, 1, 0, 0, 1, 0, 1, "R5");
    drive({2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 2'd3, 2, 0, 1, 1, 0, 1, "R5");
    // R6 64-bit form clears upper half
    drive({64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0}, {2{64'h1111}}, 2'd2, 4, 1, 1, 1, 0, 0, "R6");
    // R7 scalar
    drive({4{32'h8765_4321}}, {4{32'h1}}, 2'd2, 8, 1, 1, 1, 1, 1, "R7");
    drive({16{8'hF1}}, '0, 2'd0, 1, 1, 0, 0, 1, 1, "R7");
    // R8 shift equal to width
    drive({16{8'h80}}, '0, 2'd0, 8, 1, 0, 0, 0, 1, "R8");
    drive({16{8'h80}}, '0, 2'd0, 8, 1, 1, 0, 0, 1, "R8");
    drive({16{8'hFF}}, '0, 2'd0, 8, 0, 0, 0, 0, 1, "R8");
    drive({16{8'hFF}}, '0, 2'd0, 8, 0, 1, 0, 0, 1, "R8");
    drive({2{64'h8000_0000_0000_0000}}, '0, 2'd3, 64, 1, 0, 0, 0, 1, "R8");
    drive({2{64'hC000_0000_0000_0000}}, '0, 2'd3, 64, 0, 1, 0, 0, 1, "R8");
    idle(3);

    // mixed pseudo-random operands
    for (int v = 0; v < 600; v++) begin
      logic [127:0] s, d;
      logic [1:0] sz;
      int sh;
      bit sg, rn, ac, sc, wd;
      string tag;
      s  = {$urandom, $urandom, $urandom, $urandom};
      d  = {$urandom, $urandom, $urandom, $urandom};
      sz = 2'($urandom % 4);
      sh = 1 + int'($urandom % (8 << sz));
      sg = 1'($urandom); rn = 1'($urandom); ac = 1'($urandom);
      sc = ($urandom % 8) == 0; wd = ($urandom % 4) != 0;
      if (sh == (8 << sz))  tag = "R8";
      else if (sc)          tag = "R7";
      else if (!wd)         tag = "R6";
      else if (ac)          tag = "R5";
      else if (rn)          tag = "R4";
      else if (sg)          tag = "R3";
      else                  tag = "R2";
      drive(s, d, sz, sh, sg, rn, ac, sc, wd, tag);
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: got %0d pending results expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule